// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes. Each lookup joins that history to a few low bits of the branch word address, and the result selects one entry in a flat table of two-bit saturating counters. So each static branch owns one counter for every possible recent-history pattern, and a branch whose outcome follows from its neighbours can be learned even when its own record alone shows no pattern.

A fetch stage presents a branch PC on the lookup port. In the same cycle it gets back a taken/not-taken guess and the history value that was used. When the branch resolves, the pipeline returns the PC, that saved history and the real outcome on the update port. The addressed counter then moves one step toward the outcome, and the outcome is shifted into the history. The table has no tags, so branches that share an index share a counter. With zero history bits the block is a plain address-indexed two-bit predictor. With zero address bits it relies on global history alone.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset the history reads all zeros, and every counter holds 1 (weakly not taken), so every lookup predicts not taken.
- R2: `lk_taken` is the most significant bit of the selected counter (1 = taken). It is valid in the same cycle as `lk_pc`, with no clock edge in between.
- R3: An update with `up_taken`=1 increments the addressed counter. A counter already at its maximum (3) stays there.
- R4: An update with `up_taken`=0 decrements the addressed counter. A counter already at 0 stays there.
- R5: Each update shifts `up_taken` into history bit 0 and moves the older bits up one place; the oldest bit is dropped. `lk_hist` shows the current history.
- R6: The table index is {history, PC[ADDR_BITS+1:2]}, with history in the upper bits. A lookup uses the current history. An update uses the `up_hist` value supplied with it, not the current history.
- R7: When a lookup and an update select the same entry in the same cycle, the lookup returns the counter value from before the update.
- R8: While `up_valid` is low, neither the history nor any counter changes, whatever the other update inputs carry.
- R9: PCs that differ only above bit ADDR_BITS+1, or only in byte-offset bits [1:0], select the same counter.
- R10: For two branches whose outcomes follow each other, the dependent branch is predicted correctly on every execution after a single warm-up miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, is released in step with the clock |
| lk_pc | input | PC_W | Byte address of the branch being predicted |
| lk_taken | output | 1 | Prediction: 1 = taken |
| lk_hist | output | max(1,HIST_BITS) | History used by this lookup, to be returned with the update |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Byte address of the resolved branch |
| up_hist | input | max(1,HIST_BITS) | History that was current when this branch was predicted |
| up_taken | input | 1 | Resolved outcome: 1 = taken |

## Verification
The hardest case to reach is a lookup that uses one history pattern while the counter under test was trained under another. Every update also shifts the history, so the history is never left where the test needs it. The stimulus steers the history back by issuing sacrificial updates, with known outcomes, to unrelated addresses. Only then does it probe the trained entry. A second awkward case is a read and a write to one entry in the same cycle. For that case the entry is first trained to weakly taken and the history is restored, so that a write visible before the edge would flip the answer.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;
  // Low PC bits dropped to form a word address
  localparam int unsigned BYTE_OFF_BITS = 2;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/ghist_reg.sv
module ghist_reg #(
  parameter int unsigned HIST_BITS = 2,
  localparam int unsigned HW = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_in,
  output logic [HW-1:0] hist
);
  generate
    if (HIST_BITS > 0) begin : g_hist
      logic [HW-1:0] hist_q, hist_d;

      always_comb begin
        hist_d = HW'({hist_q, shift_in});
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
        end else if (shift_en) begin
          hist_q <= hist_d;
        end
      end

      assign hist = hist_q;

      // R5
      hist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));
      // R5
      hist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[0] == $past(shift_in));
    end else begin : g_nohist
      assign hist = '0;
    end
  endgenerate
endmodule

// File: rtl/pred_index.sv
module pred_index #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned ADDR_BITS = 4,
  localparam int unsigned HW    = (HIST_BITS > 0) ? HIST_BITS : 1,
  localparam int unsigned IDX_W = HIST_BITS + ADDR_BITS
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [HW-1:0]    hist,
  output logic [IDX_W-1:0] idx
);
  import corr_pred_pkg::*;
  localparam int unsigned LO = BYTE_OFF_BITS;

  generate
    if (HIST_BITS > 0 && ADDR_BITS > 0) begin : g_both
      assign idx = {hist, pc[LO+ADDR_BITS-1:LO]};
    end else if (HIST_BITS > 0) begin : g_hist_only
      assign idx = hist;
    end else begin : g_addr_only
      assign idx = pc[LO+ADDR_BITS-1:LO];
    end
  endgenerate
endmodule

// File: rtl/ctr_table.sv
module ctr_table #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned CTR_BITS = 2,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
  localparam logic [CTR_BITS-1:0] CTR_MIN  = '0;
  localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_BITS'((1 << (CTR_BITS-1)) - 1);

  logic [ENTRIES-1:0][CTR_BITS-1:0] tbl_q, tbl_d;
  logic [CTR_BITS-1:0] cur_ctr, nxt_ctr;

  always_comb begin
    cur_ctr = tbl_q[wr_idx];
    nxt_ctr = cur_ctr;
    if (wr_taken && cur_ctr != CTR_MAX) begin
      nxt_ctr = cur_ctr + 1'b1;
    end else if (!wr_taken && cur_ctr != CTR_MIN) begin
      nxt_ctr = cur_ctr - 1'b1;
    end
    tbl_d = tbl_q;
    tbl_d[wr_idx] = nxt_ctr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      tbl_q <= tbl_d;
    end
  end

  // Read straight from the registers: a same-cycle write is not yet visible
  assign rd_taken = tbl_q[rd_idx][CTR_BITS-1];

  // R8
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tbl_q));
  // R3
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tbl_q[wr_idx] == CTR_MAX) |=> tbl_q[$past(wr_idx)] == CTR_MAX);
  // R4
  sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tbl_q[wr_idx] == CTR_MIN) |=> tbl_q[$past(wr_idx)] == CTR_MIN);
  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && tbl_q[wr_idx] != CTR_MAX)
      |=> tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]) + 1'b1);
  // R4
  decr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && tbl_q[wr_idx] != CTR_MIN)
      |=> tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]) - 1'b1);
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned ADDR_BITS = 4,
  parameter int unsigned CTR_BITS  = 2,
  localparam int unsigned HW    = (HIST_BITS > 0) ? HIST_BITS : 1,
  localparam int unsigned IDX_W = HIST_BITS + ADDR_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [HW-1:0]   lk_hist,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [HW-1:0]   up_hist,
  input  logic            up_taken
);
  logic [HW-1:0]    cur_hist;
  logic [IDX_W-1:0] lk_idx, up_idx;

  ghist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(up_valid), .shift_in(up_taken), .hist(cur_hist)
  );

  pred_index #(.PC_W(PC_W), .HIST_BITS(HIST_BITS), .ADDR_BITS(ADDR_BITS)) u_lk_idx (
    .pc(lk_pc), .hist(cur_hist), .idx(lk_idx)
  );

  pred_index #(.PC_W(PC_W), .HIST_BITS(HIST_BITS), .ADDR_BITS(ADDR_BITS)) u_up_idx (
    .pc(up_pc), .hist(up_hist), .idx(up_idx)
  );

  ctr_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_taken(lk_taken),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_taken(up_taken)
  );

  assign lk_hist = cur_hist;
endmodule

// File: tb/corr_branch_predictor_test.sv
module corr_branch_predictor_test;
  localparam int PC_W = 32;
  localparam int HW   = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic            lk_taken, up_valid, up_taken;
  logic [HW-1:0]   lk_hist, up_hist;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  corr_branch_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_taken(up_taken)
  );

  // {pc[7:0], actual outcome, expected prediction}
  // b1 at 0x10 and b2 at 0x18, alternating pass types T,T then NT,NT
  localparam logic [9:0] VEC [12] = '{
    {8'h10,1'b1,1'b0}, {8'h18,1'b1,1'b0}, {8'h10,1'b0,1'b0}, {8'h18,1'b0,1'b0},
    {8'h10,1'b1,1'b1}, {8'h18,1'b1,1'b1}, {8'h10,1'b0,1'b0}, {8'h18,1'b0,1'b0},
    {8'h10,1'b1,1'b1}, {8'h18,1'b1,1'b1}, {8'h10,1'b0,1'b0}, {8'h18,1'b0,1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; up_valid = 1'b0; up_pc = '0; up_hist = '0; up_taken = 1'b0; lk_pc = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic [HW-1:0] h, input logic t);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_hist = h; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic probe(input string req, input logic [PC_W-1:0] pc, input int exp);
    lk_pc = pc;
    #1;
    check(req, int'(lk_taken), exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    check("R1 hist", int'(lk_hist), 0);
    probe("R1 pred 0x0", 32'h0, 0);
    probe("R1 pred 0x3c", 32'h3c, 0);

    // R2 and R10: predict/resolve loop over the vector table
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      probe($sformatf("R2/R10 step %0d", i), {24'h0, VEC[i][9:2]}, int'(VEC[i][0]));
      up_valid = 1'b1; up_pc = {24'h0, VEC[i][9:2]}; up_hist = lk_hist; up_taken = VEC[i][1];
      @(negedge clk);
      up_valid = 1'b0;
    end

    // R5 history shifting, bit 0 newest
    do_reset();
    upd(32'h40, 2'b00, 1'b1); check("R5 after T", int'(lk_hist), 1);
    upd(32'h40, 2'b00, 1'b0); check("R5 after NT", int'(lk_hist), 2);
    upd(32'h40, 2'b00, 1'b1); check("R5 after T2", int'(lk_hist), 1);
    upd(32'h40, 2'b00, 1'b1); check("R5 after T3", int'(lk_hist), 3);

    // R3 saturation at top: train {11,addr8} to 3 by four taken updates
    do_reset();
    for (int i = 0; i < 4; i++) upd(32'h20, 2'b11, 1'b1);
    upd(32'h20, 2'b11, 1'b0);                    // counter 2
    upd(32'h24, 2'b00, 1'b1); upd(32'h24, 2'b00, 1'b1); // history back to 11
    probe("R3 saturated then one NT", 32'h20, 1);
    upd(32'h20, 2'b11, 1'b0);                    // counter 1
    upd(32'h24, 2'b00, 1'b1); upd(32'h24, 2'b00, 1'b1);
    probe("R3 two NT after saturate", 32'h20, 0);

    // R4 saturation at floor on {00,addr8}
    do_reset();
    for (int i = 0; i < 3; i++) upd(32'h20, 2'b00, 1'b0);
    upd(32'h20, 2'b00, 1'b1);                    // counter 1
    upd(32'h24, 2'b11, 1'b0); upd(32'h24, 2'b11, 1'b0); // history back to 00
    probe("R4 floor then one T", 32'h20, 0);
    upd(32'h20, 2'b00, 1'b1);                    // counter 2
    upd(32'h24, 2'b11, 1'b0); upd(32'h24, 2'b11, 1'b0);
    probe("R4 floor then two T", 32'h20, 1);

    // R6 update indexes with supplied history, lookup with current history
    do_reset();
    upd(32'h20, 2'b10, 1'b1); upd(32'h20, 2'b10, 1'b1); // {10,8}=3, hist 11
    probe("R6 other history entry untouched", 32'h20, 0);
    upd(32'h24, 2'b00, 1'b0);                    // hist 10
    probe("R6 supplied history entry trained", 32'h20, 1);

    // R7 same-cycle lookup and update to one entry
    do_reset();
    upd(32'h30, 2'b00, 1'b1);                    // {00,12}=2, hist 01
    upd(32'h34, 2'b11, 1'b0); upd(32'h34, 2'b11, 1'b0); // hist 00
    @(negedge clk);
    lk_pc = 32'h30;
    up_valid = 1'b1; up_pc = 32'h30; up_hist = 2'b00; up_taken = 1'b0;
    #1;
    check("R7 pre-update value", int'(lk_taken), 1);
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    check("R7 post-update value", int'(lk_taken), 0);

    // R8 update inputs ignored while strobe is low
    do_reset();
    up_pc = 32'h10; up_hist = 2'b00; up_taken = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R8 history unchanged", int'(lk_hist), 0);
    probe("R8 counter unchanged", 32'h10, 0);

    // R9 aliasing and dropped byte offset
    do_reset();
    upd(32'h10, 2'b00, 1'b1); upd(32'h10, 2'b00, 1'b1); // {00,4}=3, hist 11
    upd(32'h3c, 2'b11, 1'b0); upd(32'h3c, 2'b11, 1'b0); // hist 00
    probe("R9 high bits alias", 32'h0000_1010, 1);
    probe("R9 byte offset dropped", 32'h11, 1);
    probe("R9 neighbour word distinct", 32'h14, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule